// File: doc/BRIEF.md
# SCSI Controller Command Front End

This block is the register-side front end of a simple SCSI bus controller. A host reaches it through a byte-wide register port with separate read and write strobes. Writes to the command register are decoded in the block. Housekeeping commands act directly on the interrupt cause, status and sequence-step registers. Selection and transfer commands are passed to an external bus sequencer as a one-cycle start pulse together with the command byte. When the sequencer finishes, it reports back through a done strobe that carries a cause, a bus phase and a step. The block drives one level interrupt line. That line always mirrors the interrupt-pending bit of the status register.

Reading the interrupt cause register is destructive. The read returns the current causes. On the same clock edge the read clears the causes, drops the terminal-count status bit, loads the command-done step code and lowers the interrupt. Bus-reset reporting can be masked by a bit in configuration register 1. Read-only registers and write-only registers may share an address, but they are held separately.

Top module: `scsi_cmd_front`

## Requirements
- R1: After reset, status (addr 4), interrupt cause (addr 5), sequence step (addr 6) and the transfer counter (addr 0 low, addr 1 middle) read 0. Addr 2 reads the chip code 0x04, configuration 1 (addr 8) reads 0x07, and irqOut, seqStart and cmdError are low.
- R2: A read of addr 5 returns the cause value held before the read. On that edge the cause register becomes 0, status bit 4 (terminal count) clears, the step becomes 4 (command done), and status bit 7 and irqOut fall.
- R3: Command 0x01 (flush) sets the cause to 0x08 (function complete) and the step to 0, and raises the interrupt.
- R4: Command 0x03 (bus reset) sets the cause to 0x80. It raises the interrupt only while configuration 1 bit 6 is 0.
- R5: Command 0x11 (command-complete sequence) sets the cause to 0x08 and status bits 2:0 to 3'b111, and raises the interrupt.
- R6: Command 0x12 (message accepted) sets the cause to 0x20 (disconnect) and the step to 0, and raises the interrupt.
- R7: Command 0x18 (pad) sets status bits 6:0 to 0x10, the cause to 0x08 and the step to 0. The interrupt bit is not changed.
- R8: Command 0x44 (enable selection) zeroes the cause and leaves the interrupt as it is. Command 0x45 (disable selection) zeroes the cause and raises the interrupt.
- R9: The command byte is bit 7 = DMA and bits 6:0 = opcode. A recognized command with DMA set copies the staged counter bytes (written at addr 0 and 1) into the working counter that addr 0 and 1 return. Until then, counter writes do not change what those addresses read.
- R10: Commands 0x10, 0x41, 0x42 and 0x43 produce seqStart high for exactly the one cycle after the write edge, with seqOpcode equal to the full written byte. They leave the cause register unchanged. Commands 0x00 and 0x1A are accepted with no effect.
- R11: Any other opcode pulses cmdError for the one cycle after the write edge. It changes no register and no output, and does not reload the counter even with DMA set.
- R12: Command 0x02 (chip reset) returns every register, seqTarget and irqOut to the R1 values.
- R13: A seqDone cycle loads the cause from seqCause, status bits 2:0 from seqPhase and the step from seqStep, and sets status bit 4 and the interrupt.
- R14: A write to addr 4 sets the write-only target field that drives seqTarget, and a read of addr 4 still returns status. Addr 3 reads back the last accepted command byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe (read side effects on this edge) |
| regAddr | input | ADDR_W | Register address |
| regWrData | input | 8 | Write data |
| regRdData | output | 8 | Read data for regAddr, combinational |
| irqOut | output | 1 | Level interrupt, equal to status bit 7 |
| seqStart | output | 1 | One-cycle start pulse to the sequencer |
| seqOpcode | output | 8 | Command byte that goes with seqStart |
| seqTarget | output | TGT_W | Target id from the write-only field at addr 4 |
| seqDone | input | 1 | Sequencer completion strobe |
| seqCause | input | 8 | Interrupt cause reported on completion |
| seqPhase | input | 3 | Bus phase reported on completion |
| seqStep | input | 3 | Sequence step reported on completion |
| cmdError | output | 1 | One-cycle pulse for an unrecognized opcode |

## Verification
The bench builds the block with its defaults: a 4-bit address, chip code 0x04, configuration reset value 0x07 and a 3-bit target id. These defaults place configuration 1 at addr 8, which sits outside the eight low addresses that the other registers use. The bench clears bit 6 of that register and later sets it, so both branches of the bus-reset mask are exercised. With the DMA bit and the staged-versus-working counter, the bench can show a reload after a recognized command and the absence of a reload after an unknown one.

// File: rtl/scsi_cmd_pkg.sv
package scsi_cmd_pkg;

  localparam int CNT_BYTES = 2;

  // register addresses
  localparam int A_CNT0 = 0;
  localparam int A_ID   = 2;
  localparam int A_CMD  = 3;
  localparam int A_STAT = 4;
  localparam int A_INTR = 5;
  localparam int A_SEQ  = 6;
  localparam int A_CFG1 = 8;

  localparam logic [7:0] CAUSE_RST  = 8'h80;
  localparam logic [7:0] CAUSE_DISC = 8'h20;
  localparam logic [7:0] CAUSE_FC   = 8'h08;

  localparam int ST_IRQ = 7;
  localparam int ST_TC  = 4;
  localparam int CFG_RST_MASK_BIT = 6;

  localparam logic [2:0] STEP_DONE   = 3'd4;
  localparam logic [2:0] PHASE_MSGIN = 3'b111;

  typedef enum logic [6:0] {
    OP_NOP     = 7'h00,
    OP_FLUSH   = 7'h01,
    OP_CHIPRST = 7'h02,
    OP_BUSRST  = 7'h03,
    OP_XFER    = 7'h10,
    OP_ICCS    = 7'h11,
    OP_MSGOK   = 7'h12,
    OP_PAD     = 7'h18,
    OP_SETATN  = 7'h1A,
    OP_SEL     = 7'h41,
    OP_SELATN  = 7'h42,
    OP_SELSTOP = 7'h43,
    OP_ENSEL   = 7'h44,
    OP_DISSEL  = 7'h45
  } opcode_e;

  typedef struct packed {
    logic accept;
    logic reload;
    logic flush;
    logic chipRst;
    logic busRst;
    logic iccs;
    logic msgOk;
    logic pad;
    logic enSel;
    logic disSel;
  } cmd_strobe_t;

endpackage

// File: rtl/scsi_cmd_ctrl.sv
module scsi_cmd_ctrl
  import scsi_cmd_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wrCmd,
  input  logic [7:0]  cmdByte,
  output cmd_strobe_t cmdStb,
  output logic        seqStart,
  output logic [7:0]  seqOpcode,
  output logic        cmdError
);

  logic known;
  logic dispatch;

  always_comb begin
    cmdStb   = '0;
    known    = 1'b1;
    dispatch = 1'b0;
    case (cmdByte[6:0])
      OP_NOP, OP_SETATN: ;
      OP_FLUSH:   cmdStb.flush   = wrCmd;
      OP_CHIPRST: cmdStb.chipRst = wrCmd;
      OP_BUSRST:  cmdStb.busRst  = wrCmd;
      OP_ICCS:    cmdStb.iccs    = wrCmd;
      OP_MSGOK:   cmdStb.msgOk   = wrCmd;
      OP_PAD:     cmdStb.pad     = wrCmd;
      OP_ENSEL:   cmdStb.enSel   = wrCmd;
      OP_DISSEL:  cmdStb.disSel  = wrCmd;
      OP_XFER, OP_SEL, OP_SELATN, OP_SELSTOP: dispatch = 1'b1;
      default:    known = 1'b0;
    endcase
    cmdStb.accept = wrCmd & known;
    cmdStb.reload = wrCmd & known & cmdByte[7];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seqStart  <= 1'b0;
      seqOpcode <= '0;
      cmdError  <= 1'b0;
    end else begin
      seqStart <= wrCmd & dispatch;
      cmdError <= wrCmd & ~known;
      if (wrCmd & dispatch) seqOpcode <= cmdByte;
    end
  end

endmodule

// File: rtl/scsi_cmd_regs.sv
module scsi_cmd_regs
  import scsi_cmd_pkg::*;
#(
  parameter int         ADDR_W    = 4,
  parameter logic [7:0] CHIP_ID   = 8'h04,
  parameter logic [7:0] CFG1_INIT = 8'h07,
  parameter int         TGT_W     = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wrData,
  input  cmd_strobe_t       cmdStb,
  input  logic              seqDone,
  input  logic [7:0]        seqCause,
  input  logic [2:0]        seqPhase,
  input  logic [2:0]        seqStep,
  output logic [7:0]        rdData,
  output logic              irqOut,
  output logic              cfgRstMask,
  output logic [TGT_W-1:0]  seqTarget
);

  logic [7:0] stagedCnt [CNT_BYTES];
  logic [7:0] workCnt   [CNT_BYTES];
  logic [7:0] statR, intrR, cfg1R, cmdR;
  logic [2:0] seqR;
  logic [7:0] statN, intrN;
  logic [2:0] seqN;
  logic       rdIntr;

  assign rdIntr = rdEn && (addr == ADDR_W'(A_INTR));

  // counter byte lanes: staged (host write) and working (read back)
  for (genvar g = 0; g < CNT_BYTES; g++) begin : gLane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stagedCnt[g] <= '0;
        workCnt[g]   <= '0;
      end else if (cmdStb.chipRst) begin
        stagedCnt[g] <= '0;
        workCnt[g]   <= '0;
      end else begin
        if (wrEn && addr == ADDR_W'(A_CNT0 + g)) stagedCnt[g] <= wrData;
        if (cmdStb.reload) workCnt[g] <= stagedCnt[g];
      end
    end
  end

  // ordered updates: destructive read, then sequencer report, then command
  always_comb begin
    statN = statR;
    intrN = intrR;
    seqN  = seqR;
    if (rdIntr) begin
      intrN         = '0;
      statN[ST_TC]  = 1'b0;
      statN[ST_IRQ] = 1'b0;
      seqN          = STEP_DONE;
    end
    if (seqDone) begin
      intrN         = seqCause;
      statN[2:0]    = seqPhase;
      statN[ST_TC]  = 1'b1;
      statN[ST_IRQ] = 1'b1;
      seqN          = seqStep;
    end
    if (cmdStb.flush) begin
      intrN         = CAUSE_FC;
      seqN          = '0;
      statN[ST_IRQ] = 1'b1;
    end
    if (cmdStb.busRst) begin
      intrN = CAUSE_RST;
      if (!cfg1R[CFG_RST_MASK_BIT]) statN[ST_IRQ] = 1'b1;
    end
    if (cmdStb.iccs) begin
      intrN         = CAUSE_FC;
      statN[2:0]    = PHASE_MSGIN;
      statN[ST_IRQ] = 1'b1;
    end
    if (cmdStb.msgOk) begin
      intrN         = CAUSE_DISC;
      seqN          = '0;
      statN[ST_IRQ] = 1'b1;
    end
    if (cmdStb.pad) begin
      statN[6:0] = 7'h10;
      intrN      = CAUSE_FC;
      seqN       = '0;
    end
    if (cmdStb.enSel) intrN = '0;
    if (cmdStb.disSel) begin
      intrN         = '0;
      statN[ST_IRQ] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      statR     <= '0;
      intrR     <= '0;
      seqR      <= '0;
      cfg1R     <= CFG1_INIT;
      cmdR      <= '0;
      seqTarget <= '0;
    end else if (cmdStb.chipRst) begin
      statR     <= '0;
      intrR     <= '0;
      seqR      <= '0;
      cfg1R     <= CFG1_INIT;
      cmdR      <= '0;
      seqTarget <= '0;
    end else begin
      statR <= statN;
      intrR <= intrN;
      seqR  <= seqN;
      if (cmdStb.accept) cmdR <= wrData;
      if (wrEn && addr == ADDR_W'(A_CFG1)) cfg1R <= wrData;
      if (wrEn && addr == ADDR_W'(A_STAT)) seqTarget <= wrData[TGT_W-1:0];
    end
  end

  always_comb begin
    rdData = '0;
    for (int i = 0; i < CNT_BYTES; i++)
      if (addr == ADDR_W'(A_CNT0 + i)) rdData = workCnt[i];
    if (addr == ADDR_W'(A_ID))   rdData = CHIP_ID;
    if (addr == ADDR_W'(A_CMD))  rdData = cmdR;
    if (addr == ADDR_W'(A_STAT)) rdData = statR;
    if (addr == ADDR_W'(A_INTR)) rdData = intrR;
    if (addr == ADDR_W'(A_SEQ))  rdData = {5'b0, seqR};
    if (addr == ADDR_W'(A_CFG1)) rdData = cfg1R;
  end

  assign irqOut     = statR[ST_IRQ];
  assign cfgRstMask = cfg1R[CFG_RST_MASK_BIT];

endmodule

// File: rtl/scsi_cmd_front.sv
module scsi_cmd_front
  import scsi_cmd_pkg::*;
#(
  parameter int         ADDR_W    = 4,
  parameter logic [7:0] CHIP_ID   = 8'h04,
  parameter logic [7:0] CFG1_INIT = 8'h07,
  parameter int         TGT_W     = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [7:0]        regWrData,
  output logic [7:0]        regRdData,
  output logic              irqOut,
  output logic              seqStart,
  output logic [7:0]        seqOpcode,
  output logic [TGT_W-1:0]  seqTarget,
  input  logic              seqDone,
  input  logic [7:0]        seqCause,
  input  logic [2:0]        seqPhase,
  input  logic [2:0]        seqStep,
  output logic              cmdError
);

  cmd_strobe_t cmdStb;
  logic        wrCmd;
  logic        cfgRstMask;

  assign wrCmd = regWrEn && (regAddr == ADDR_W'(A_CMD));

  scsi_cmd_ctrl uCtrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .wrCmd     (wrCmd),
    .cmdByte   (regWrData),
    .cmdStb    (cmdStb),
    .seqStart  (seqStart),
    .seqOpcode (seqOpcode),
    .cmdError  (cmdError)
  );

  scsi_cmd_regs #(
    .ADDR_W    (ADDR_W),
    .CHIP_ID   (CHIP_ID),
    .CFG1_INIT (CFG1_INIT),
    .TGT_W     (TGT_W)
  ) uRegs (
    .clk        (clk),
    .rst_n      (rst_n),
    .wrEn       (regWrEn),
    .rdEn       (regRdEn),
    .addr       (regAddr),
    .wrData     (regWrData),
    .cmdStb     (cmdStb),
    .seqDone    (seqDone),
    .seqCause   (seqCause),
    .seqPhase   (seqPhase),
    .seqStep    (seqStep),
    .rdData     (regRdData),
    .irqOut     (irqOut),
    .cfgRstMask (cfgRstMask),
    .seqTarget  (seqTarget)
  );

endmodule

// File: rtl/scsi_cmd_front_chk.sv
module scsi_cmd_front_chk
  import scsi_cmd_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              regWrEn,
  input logic              regRdEn,
  input logic [ADDR_W-1:0] regAddr,
  input logic [7:0]        regWrData,
  input logic              irqOut,
  input logic              seqStart,
  input logic              seqDone,
  input logic              cmdError,
  input logic              cfgRstMask
);

  logic wrCmdC, rdIntrC;
  assign wrCmdC  = regWrEn && (regAddr == ADDR_W'(A_CMD));
  assign rdIntrC = regRdEn && (regAddr == ADDR_W'(A_INTR));

  AST_INTR_READ_LOWERS: assert property (@(posedge clk) disable iff (!rst_n)
    (rdIntrC && !wrCmdC && !seqDone) |=> !irqOut); // R2

  AST_FLUSH_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
    (wrCmdC && regWrData[6:0] == 7'h01) |=> irqOut); // R3

  AST_BUSRST_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (wrCmdC && regWrData[6:0] == 7'h03 && cfgRstMask && !irqOut && !seqDone) |=> !irqOut); // R4

  AST_DISSEL_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
    (wrCmdC && regWrData[6:0] == 7'h45) |=> irqOut); // R8

  AST_START_FROM_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    seqStart |-> $past(wrCmdC)); // R10

  AST_ERROR_FROM_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    cmdError |-> $past(wrCmdC)); // R11

  AST_ERROR_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmdError && seqStart)); // R11

  AST_DONE_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
    (seqDone && !(wrCmdC && regWrData[6:0] == 7'h02)) |=> irqOut); // R13

endmodule

bind scsi_cmd_front scsi_cmd_front_chk #(.ADDR_W(ADDR_W)) uChk (
  .clk        (clk),
  .rst_n      (rst_n),
  .regWrEn    (regWrEn),
  .regRdEn    (regRdEn),
  .regAddr    (regAddr),
  .regWrData  (regWrData),
  .irqOut     (irqOut),
  .seqStart   (seqStart),
  .seqDone    (seqDone),
  .cmdError   (cmdError),
  .cfgRstMask (cfgRstMask)
);

// File: tb/tb_scsi_cmd_front.sv
`timescale 1ns/100ps
module tb_scsi_cmd_front;

  typedef struct packed {
    logic       wr;
    logic [3:0] addr;
    logic [7:0] val;
    logic       irq;
  } vec_t;

  localparam int NV = 42;
  // write vectors store val; read vectors compare val and irq (before side effect)
  localparam vec_t VECS [NV] = '{
    '{1'b0, 4'd2, 8'h04, 1'b0},  // R1 chip code
    '{1'b0, 4'd8, 8'h07, 1'b0},  // R1 cfg1
    '{1'b0, 4'd4, 8'h00, 1'b0},  // R1 status
    '{1'b1, 4'd3, 8'h01, 1'b0},  // flush
    '{1'b0, 4'd5, 8'h08, 1'b1},  // R3 cause, then R2 clear
    '{1'b0, 4'd6, 8'h04, 1'b0},  // R2 step done
    '{1'b0, 4'd5, 8'h00, 1'b0},  // R2 cleared
    '{1'b1, 4'd3, 8'h12, 1'b0},  // message accepted
    '{1'b0, 4'd6, 8'h00, 1'b1},  // R6 step
    '{1'b0, 4'd5, 8'h20, 1'b1},  // R6 cause
    '{1'b1, 4'd3, 8'h11, 1'b0},  // iccs
    '{1'b0, 4'd4, 8'h87, 1'b1},  // R5 status
    '{1'b0, 4'd5, 8'h08, 1'b1},  // R5 cause
    '{1'b0, 4'd4, 8'h07, 1'b0},  // R2 irq bit cleared
    '{1'b1, 4'd3, 8'h18, 1'b0},  // pad
    '{1'b0, 4'd4, 8'h10, 1'b0},  // R7 status, no irq
    '{1'b0, 4'd6, 8'h00, 1'b0},  // R7 step
    '{1'b0, 4'd5, 8'h08, 1'b0},  // R7 cause
    '{1'b0, 4'd4, 8'h00, 1'b0},  // R2 tc cleared
    '{1'b1, 4'd3, 8'h03, 1'b0},  // bus reset, unmasked
    '{1'b0, 4'd5, 8'h80, 1'b1},  // R4 raised
    '{1'b1, 4'd8, 8'h47, 1'b0},  // mask bus reset report
    '{1'b0, 4'd8, 8'h47, 1'b0},  // R4 cfg readback
    '{1'b1, 4'd3, 8'h03, 1'b0},  // bus reset, masked
    '{1'b0, 4'd5, 8'h80, 1'b0},  // R4 not raised
    '{1'b1, 4'd3, 8'h45, 1'b0},  // disable selection
    '{1'b0, 4'd5, 8'h00, 1'b1},  // R8 raised, cause zero
    '{1'b1, 4'd3, 8'h01, 1'b0},  // flush
    '{1'b1, 4'd3, 8'h44, 1'b0},  // enable selection
    '{1'b0, 4'd5, 8'h00, 1'b1},  // R8 cause zero, irq kept
    '{1'b0, 4'd3, 8'h44, 1'b0},  // R14 command readback
    '{1'b1, 4'd0, 8'h34, 1'b0},
    '{1'b1, 4'd1, 8'h12, 1'b0},
    '{1'b0, 4'd0, 8'h00, 1'b0},  // R9 no reload yet
    '{1'b1, 4'd3, 8'h80, 1'b0},  // nop with dma
    '{1'b0, 4'd0, 8'h34, 1'b0},  // R9 lo
    '{1'b0, 4'd1, 8'h12, 1'b0},  // R9 mid
    '{1'b1, 4'd0, 8'hAA, 1'b0},
    '{1'b1, 4'd3, 8'hFF, 1'b0},  // unknown with dma
    '{1'b0, 4'd0, 8'h34, 1'b0},  // R11 no reload
    '{1'b0, 4'd3, 8'h80, 1'b0},  // R11 command readback kept
    '{1'b1, 4'd4, 8'h05, 1'b0}   // target id write
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       regWrEn = 1'b0, regRdEn = 1'b0;
  logic [3:0] regAddr = '0;
  logic [7:0] regWrData = '0;
  logic [7:0] regRdData;
  logic       irqOut, seqStart, cmdError, seqDone = 1'b0;
  logic [7:0] seqOpcode, seqCause = '0;
  logic [2:0] seqTarget, seqPhase = '0, seqStep = '0;

  int nChk = 0, nBad = 0;

  always #2.5 clk = ~clk;

  scsi_cmd_front dut (
    .clk(clk), .rst_n(rst_n), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .irqOut(irqOut), .seqStart(seqStart), .seqOpcode(seqOpcode),
    .seqTarget(seqTarget), .seqDone(seqDone), .seqCause(seqCause),
    .seqPhase(seqPhase), .seqStep(seqStep), .cmdError(cmdError)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic doWrite(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(posedge clk);
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic doRead(input string tag, input logic [3:0] a,
                        input logic [7:0] exp, input logic expIrq);
    @(negedge clk);
    regRdEn = 1'b1; regAddr = a;
    #1;
    check(tag, regRdData, exp);
    check({tag, " irq"}, {7'b0, irqOut}, {7'b0, expIrq});
    @(posedge clk);
    @(negedge clk);
    regRdEn = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nBad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nBad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    check("R1 seqStart", {7'b0, seqStart}, 8'h00);
    check("R1 cmdError", {7'b0, cmdError}, 8'h00);
    check("R1 irqOut", {7'b0, irqOut}, 8'h00);

    for (int i = 0; i < NV; i++) begin
      if (VECS[i].wr) doWrite(VECS[i].addr, VECS[i].val);
      else doRead($sformatf("vec%0d", i), VECS[i].addr, VECS[i].val, VECS[i].irq);
    end

    // R14 write-only target field does not alias status
    doRead("R14 status at addr 4", 4'd4, 8'h00, 1'b0);
    check("R14 seqTarget", {5'b0, seqTarget}, 8'h05);

    // R10 dispatch with dma (also reloads staged AA)
    doWrite(4'd3, 8'hC2);
    check("R10 seqStart high", {7'b0, seqStart}, 8'h01);
    check("R10 seqOpcode", seqOpcode, 8'hC2);
    @(negedge clk);
    check("R10 seqStart one cycle", {7'b0, seqStart}, 8'h00);
    doRead("R9 reload on dispatch", 4'd0, 8'hAA, 1'b0);
    doRead("R10 cause untouched", 4'd5, 8'h00, 1'b0);

    // R11 unknown opcode
    doWrite(4'd3, 8'h7F);
    check("R11 cmdError high", {7'b0, cmdError}, 8'h01);
    check("R11 no start", {7'b0, seqStart}, 8'h00);
    @(negedge clk);
    check("R11 cmdError one cycle", {7'b0, cmdError}, 8'h00);
    doRead("R11 readback kept", 4'd3, 8'hC2, 1'b0);

    // R10 set-ATN accepted quietly
    doWrite(4'd3, 8'h1A);
    check("R10 setatn no error", {7'b0, cmdError}, 8'h00);
    check("R10 setatn no start", {7'b0, seqStart}, 8'h00);
    doRead("R10 setatn readback", 4'd3, 8'h1A, 1'b0);

    // R13 sequencer completion
    @(negedge clk);
    seqDone = 1'b1; seqCause = 8'h18; seqPhase = 3'b001; seqStep = 3'b010;
    @(posedge clk);
    @(negedge clk);
    seqDone = 1'b0;
    doRead("R13 status", 4'd4, 8'h91, 1'b1);
    doRead("R13 step", 4'd6, 8'h02, 1'b1);
    doRead("R13 cause", 4'd5, 8'h18, 1'b1);
    doRead("R2 after done read", 4'd4, 8'h01, 1'b0);

    // R12 chip reset
    doWrite(4'd3, 8'h01);
    check("R12 irq before reset", {7'b0, irqOut}, 8'h01);
    doWrite(4'd3, 8'h02);
    check("R12 irq low", {7'b0, irqOut}, 8'h00);
    check("R12 target cleared", {5'b0, seqTarget}, 8'h00);
    doRead("R12 cfg1", 4'd8, 8'h07, 1'b0);
    doRead("R12 counter", 4'd0, 8'h00, 1'b0);
    doRead("R12 cause", 4'd5, 8'h00, 1'b0);
    doRead("R12 chip code", 4'd2, 8'h04, 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", nChk, nBad);
    $finish;
  end

endmodule